// File: doc/BRIEF.md
# Dual-Bank IN Endpoint Buffer Controller

This block holds the transmit data of one USB IN endpoint in two banks of `BANK_BYTES` bytes each. A local writer fills one bank while the host side drains the other. The writer is either a CPU byte port or a streaming flow port, picked by a mode input. The block keeps track of which bank the writer owns and which bank waits for the host. It tells the writer whether a byte may be written now, and it raises a transmit-ready flag each time the writer is given a free bank. That flag can drive an interrupt.

A bank passes from writer to host in one of two ways. In manual mode the writer sends a release pulse. In auto mode the handover happens on the write that fills the bank. Auto mode has one exception for the flow port: when an end-of-transfer marker arrives while a bank is only partly filled, that bank waits for an explicit release. The host reads bytes by index from its current bank. A done pulse then frees that bank and moves the host to the other bank. When the host aborts a transfer, for example after a zero-length OUT packet arrives during an IN stage, a kill pulse throws away the most recently handed-over bank that the host has not yet finished.

Top module: `ifb_in_buffer`

## Requirements
- R1: After reset both banks are free, `wr_count` is 0, `wr_allow` is 1, `tx_ready` is 1 and `hs_ready` is 0.
- R2: A write is accepted only while `wr_allow` is 1, and each accepted write adds one to `wr_count`. `wr_allow` falls once the writer's bank holds `BANK_BYTES` bytes. A write attempted while `wr_allow` is 0 leaves `wr_count` unchanged.
- R3: With `cfg_flow`=1 the bytes come from the flow port and the CPU port is ignored. With `cfg_flow`=0 the bytes come from the CPU port and the flow port is ignored.
- R4: With `cfg_auto`=0, a `rel_bank` pulse hands the writer's bank to the host with its byte count, whether that bank is full, partly filled or empty (an empty bank is a zero-length packet). The writer then moves to the other bank.
- R5: With `cfg_auto`=1, the write that fills a bank hands it to the host in the same clock. `rel_bank` has no effect unless an end-of-transfer is pending (R6).
- R6: With `cfg_flow`=1 and `cfg_auto`=1, a `flow_eot` pulse that arrives while the writer's bank is partly filled blocks any further writes and holds the bank back. A later `rel_bank` pulse hands the bank to the host.
- R7: `tx_ready` sets when the writer is given a free bank. This happens on a handover when the other bank is free, on a host done of the bank the writer was waiting for, and on a kill. A `tx_ack` pulse clears it, but a set in the same clock wins. `tx_irq` equals `tx_ready` AND `tx_ie`.
- R8: `hs_data` is the byte at index `hs_addr` of the host's bank, in write order. Banks reach the host in the order they were handed over.
- R9: An `hs_done` pulse while `hs_ready` is 1 frees the host's bank, sets its count to zero and moves the host to the other bank. While `hs_ready` is 0 it has no effect.
- R10: A `kill_bank` pulse frees the most recently handed-over bank that is still pending. It has no effect if that bank is not pending, or if a handover happens in the same clock, or if the host finishes that same bank in the same clock.
- R11: The writer fills one bank while the host holds the other. When both banks are pending, `wr_allow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto | input | 1 | 1: bank is handed over automatically when full |
| cfg_flow | input | 1 | 1: writer is the flow port, 0: CPU port |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_data | input | DATA_W | CPU write byte |
| flow_wr | input | 1 | Flow port write strobe |
| flow_data | input | DATA_W | Flow port write byte |
| flow_eot | input | 1 | Flow port end-of-transfer pulse |
| rel_bank | input | 1 | Writer release pulse |
| tx_ack | input | 1 | Clears the transmit-ready flag |
| tx_ie | input | 1 | Transmit-ready interrupt enable |
| kill_bank | input | 1 | Discard the last handed-over bank |
| hs_addr | input | IDX_W | Host read index |
| hs_done | input | 1 | Host finished its current bank |
| wr_allow | output | 1 | Writer may write a byte |
| wr_count | output | CNT_W | Bytes in the writer's bank |
| tx_ready | output | 1 | Transmit-ready flag |
| tx_irq | output | 1 | Transmit-ready interrupt |
| hs_ready | output | 1 | Host's bank holds a packet |
| hs_count | output | CNT_W | Byte count of the host's bank |
| hs_data | output | DATA_W | Byte read by the host |

## Verification
Directed runs cover the following cases:
- a partial handover, an empty handover and a full handover in manual mode, which separate the count kept on handover from the count cleared on free;
- a fill-to-full write in auto mode followed by a release pulse, which checks that the pulse is ignored;
- an end-of-transfer on a partly filled flow bank, which separates holding the bank from handing it over;
- a kill with both banks pending and a kill with none pending, which check the target bank and the no-effect case.

A randomized stream then runs in each of the four mode combinations. It mixes overlapping writes, releases, acks, kills and host done pulses, and a behavioural model compares every output on every clock. This is where same-clock collisions show up, such as a handover against a done or a kill against a handover.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_FLOW = 1'b1
    } wr_src_e;

    function automatic logic other_bank(input logic b);
        return ~b;
    endfunction
endpackage

// File: rtl/ifb_wr_select.sv
module ifb_wr_select
    import ifb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              cfg_flow,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              flow_wr,
    input  logic [DATA_W-1:0] flow_data,
    output logic              wr_req,
    output logic [DATA_W-1:0] wr_data
);
    wr_src_e src;

    always_comb begin
        src = cfg_flow ? SRC_FLOW : SRC_CPU;
        if (src == SRC_FLOW) begin
            wr_req  = flow_wr;
            wr_data = flow_data;
        end else begin
            wr_req  = cpu_wr;
            wr_data = cpu_data;
        end
    end
endmodule

// File: rtl/ifb_bank_store.sv
module ifb_bank_store #(
    parameter int BANK_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] mem_q [BANK_BYTES];

        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) begin
                mem_q[widx] <= wdata;
            end
        end

        always_comb begin
            if (32'(raddr) < BANK_BYTES) begin
                bank_rd[b] = mem_q[raddr];
            end else begin
                bank_rd[b] = '0;
            end
        end
    end

    assign rdata = bank_rd[rbank];
endmodule

// File: rtl/ifb_bank_ctrl.sv
module ifb_bank_ctrl
    import ifb_pkg::*;
#(
    parameter int BANK_BYTES = 8,
    localparam int IDX_W     = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_auto,
    input  logic             cfg_flow,
    input  logic             wr_req,
    input  logic             flow_eot,
    input  logic             rel_bank,
    input  logic             tx_ack,
    input  logic             kill_bank,
    input  logic             hs_done,
    output logic             wr_allow,
    output logic             wr_fire,
    output logic             wr_bank,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] wr_count,
    output logic             tx_ready,
    output logic             hs_bank,
    output logic             hs_ready,
    output logic [CNT_W-1:0] hs_count
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BANK_BYTES);

    typedef struct packed {
        logic                  wp;
        logic                  hp;
        logic [1:0]            rdy;
        logic [1:0][CNT_W-1:0] cnt;
        logic                  eot_hold;
        logic                  txr;
    } state_t;

    state_t           s_q, s_d;
    logic             allow_c;
    logic             fire_c;
    logic [CNT_W-1:0] cnt_after;
    logic             commit_c;
    logic             done_c;
    logic             victim;
    logic             kill_c;
    logic             set_txr;

    always_comb begin
        s_d       = s_q;
        allow_c   = !s_q.rdy[s_q.wp] && (s_q.cnt[s_q.wp] < FULL) && !s_q.eot_hold;
        fire_c    = allow_c && wr_req;
        cnt_after = s_q.cnt[s_q.wp] + CNT_W'(fire_c);
        if (cfg_auto) begin
            commit_c = !s_q.rdy[s_q.wp] &&
                       ((fire_c && (cnt_after == FULL)) || (rel_bank && s_q.eot_hold));
        end else begin
            commit_c = !s_q.rdy[s_q.wp] && rel_bank;
        end
        done_c = hs_done && s_q.rdy[s_q.hp];
        victim = other_bank(s_q.wp);
        kill_c = kill_bank && s_q.rdy[victim] && !commit_c &&
                 !(done_c && (s_q.hp == victim));

        s_d.cnt[s_q.wp] = cnt_after;

        if (commit_c) begin
            s_d.rdy[s_q.wp] = 1'b1;
            s_d.wp          = other_bank(s_q.wp);
            s_d.eot_hold    = 1'b0;
        end else if (cfg_flow && cfg_auto && flow_eot && !s_q.rdy[s_q.wp] &&
                     (cnt_after != '0) && (cnt_after != FULL)) begin
            s_d.eot_hold = 1'b1;
        end

        if (done_c) begin
            s_d.rdy[s_q.hp] = 1'b0;
            s_d.cnt[s_q.hp] = '0;
            s_d.hp          = other_bank(s_q.hp);
        end

        if (kill_c) begin
            s_d.rdy[victim] = 1'b0;
            s_d.cnt[victim] = '0;
            if (!s_q.rdy[s_q.wp] && (cnt_after != '0)) begin
                s_d.hp = s_q.wp;
            end else begin
                s_d.wp = victim;
            end
        end

        set_txr = (commit_c && !s_d.rdy[s_d.wp]) ||
                  (done_c && (s_q.hp == s_q.wp)) ||
                  kill_c;
        s_d.txr = set_txr || (s_q.txr && !tx_ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.txr      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_allow = allow_c;
    assign wr_fire  = fire_c;
    assign wr_bank  = s_q.wp;
    assign wr_idx   = s_q.cnt[s_q.wp][IDX_W-1:0];
    assign wr_count = s_q.cnt[s_q.wp];
    assign tx_ready = s_q.txr;
    assign hs_bank  = s_q.hp;
    assign hs_ready = s_q.rdy[s_q.hp];
    assign hs_count = s_q.cnt[s_q.hp];
endmodule

// File: rtl/ifb_in_buffer.sv
module ifb_in_buffer #(
    parameter int BANK_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_auto,
    input  logic              cfg_flow,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              flow_wr,
    input  logic [DATA_W-1:0] flow_data,
    input  logic              flow_eot,
    input  logic              rel_bank,
    input  logic              tx_ack,
    input  logic              tx_ie,
    input  logic              kill_bank,
    input  logic [IDX_W-1:0]  hs_addr,
    input  logic              hs_done,
    output logic              wr_allow,
    output logic [CNT_W-1:0]  wr_count,
    output logic              tx_ready,
    output logic              tx_irq,
    output logic              hs_ready,
    output logic [CNT_W-1:0]  hs_count,
    output logic [DATA_W-1:0] hs_data
);
    logic              wr_req;
    logic [DATA_W-1:0] wr_data;
    logic              wr_fire;
    logic              wr_bank;
    logic [IDX_W-1:0]  wr_idx;
    logic              hs_bank;

    ifb_wr_select #(.DATA_W(DATA_W)) u_sel (
        .cfg_flow  (cfg_flow),
        .cpu_wr    (cpu_wr),
        .cpu_data  (cpu_data),
        .flow_wr   (flow_wr),
        .flow_data (flow_data),
        .wr_req    (wr_req),
        .wr_data   (wr_data)
    );

    ifb_bank_ctrl #(.BANK_BYTES(BANK_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_auto  (cfg_auto),
        .cfg_flow  (cfg_flow),
        .wr_req    (wr_req),
        .flow_eot  (flow_eot),
        .rel_bank  (rel_bank),
        .tx_ack    (tx_ack),
        .kill_bank (kill_bank),
        .hs_done   (hs_done),
        .wr_allow  (wr_allow),
        .wr_fire   (wr_fire),
        .wr_bank   (wr_bank),
        .wr_idx    (wr_idx),
        .wr_count  (wr_count),
        .tx_ready  (tx_ready),
        .hs_bank   (hs_bank),
        .hs_ready  (hs_ready),
        .hs_count  (hs_count)
    );

    ifb_bank_store #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (wr_fire),
        .wbank (wr_bank),
        .widx  (wr_idx),
        .wdata (wr_data),
        .rbank (hs_bank),
        .raddr (hs_addr),
        .rdata (hs_data)
    );

    assign tx_irq = tx_ready && tx_ie;
endmodule

// File: rtl/ifb_checker.sv
module ifb_checker #(
    parameter int BANK_BYTES = 8,
    localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_auto,
    input logic             cfg_flow,
    input logic             cpu_wr,
    input logic             flow_wr,
    input logic             rel_bank,
    input logic             tx_ack,
    input logic             kill_bank,
    input logic             hs_done,
    input logic             wr_allow,
    input logic [CNT_W-1:0] wr_count,
    input logic             tx_ready,
    input logic             hs_ready,
    input logic [CNT_W-1:0] hs_count
);
    logic req;
    assign req = cfg_flow ? flow_wr : cpu_wr;

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wr_count) <= BANK_BYTES);

    assert_blocked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow && !rel_bank && !kill_bank && !hs_done) |=> $stable(wr_count));

    assert_manual_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_auto && rel_bank && !hs_ready) |=> hs_ready);

    assert_auto_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto && !hs_ready && wr_allow && req && (32'(wr_count) == BANK_BYTES - 1))
        |=> (hs_ready && (32'(hs_count) == BANK_BYTES)));

    assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_ack) |=> tx_ready);
endmodule

bind ifb_in_buffer ifb_checker #(.BANK_BYTES(BANK_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_auto  (cfg_auto),
    .cfg_flow  (cfg_flow),
    .cpu_wr    (cpu_wr),
    .flow_wr   (flow_wr),
    .rel_bank  (rel_bank),
    .tx_ack    (tx_ack),
    .kill_bank (kill_bank),
    .hs_done   (hs_done),
    .wr_allow  (wr_allow),
    .wr_count  (wr_count),
    .tx_ready  (tx_ready),
    .hs_ready  (hs_ready),
    .hs_count  (hs_count)
);

// File: tb/test_ifb_in_buffer.sv
module test_ifb_in_buffer;
    localparam int N      = 8;
    localparam int DW     = 8;
    localparam int IW     = 3;
    localparam int CW     = 4;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto = 0, cfg_flow = 0;
    logic cpu_wr = 0, flow_wr = 0, flow_eot = 0, rel_bank = 0;
    logic tx_ack = 0, tx_ie = 0, kill_bank = 0, hs_done = 0;
    logic [DW-1:0] cpu_data = '0, flow_data = '0;
    logic [IW-1:0] hs_addr = '0;
    logic          wr_allow, tx_ready, tx_irq, hs_ready;
    logic [CW-1:0] wr_count, hs_count;
    logic [DW-1:0] hs_data;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    int m_wb, m_hb, m_eotp, m_txr;
    int m_cnt [2];
    int m_rdy [2];
    int m_mem [2][N];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ifb_in_buffer #(.BANK_BYTES(N), .DATA_W(DW)) i_ifb_in_buffer (
        .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_flow(cfg_flow),
        .cpu_wr(cpu_wr), .cpu_data(cpu_data), .flow_wr(flow_wr), .flow_data(flow_data),
        .flow_eot(flow_eot), .rel_bank(rel_bank), .tx_ack(tx_ack), .tx_ie(tx_ie),
        .kill_bank(kill_bank), .hs_addr(hs_addr), .hs_done(hs_done),
        .wr_allow(wr_allow), .wr_count(wr_count), .tx_ready(tx_ready), .tx_irq(tx_irq),
        .hs_ready(hs_ready), .hs_count(hs_count), .hs_data(hs_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model();
        int req, dat, full, give, take, vic, kill_ok, owb, ohb, ordy;
        if (!rst_n) begin
            m_wb = 0; m_hb = 0; m_eotp = 0; m_txr = 1;
            m_cnt[0] = 0; m_cnt[1] = 0; m_rdy[0] = 0; m_rdy[1] = 0;
            return;
        end
        req  = cfg_flow ? int'(flow_wr) : int'(cpu_wr);
        dat  = cfg_flow ? int'(flow_data) : int'(cpu_data);
        full = 0;
        if (!m_rdy[m_wb] && m_cnt[m_wb] < N && !m_eotp && req != 0) begin
            m_mem[m_wb][m_cnt[m_wb]] = dat;
            m_cnt[m_wb]++;
            full = (m_cnt[m_wb] == N);
        end
        if (cfg_auto) give = !m_rdy[m_wb] && (full || (rel_bank && m_eotp));
        else          give = !m_rdy[m_wb] && rel_bank;
        take    = hs_done && m_rdy[m_hb];
        vic     = 1 - m_wb;
        kill_ok = kill_bank && m_rdy[vic] && !give && !(take && m_hb == vic);
        owb = m_wb; ohb = m_hb; ordy = m_rdy[m_wb];
        if (give) begin
            m_rdy[owb] = 1; m_wb = 1 - owb; m_eotp = 0;
        end else if (cfg_flow && cfg_auto && flow_eot && !ordy &&
                     m_cnt[owb] > 0 && m_cnt[owb] < N) begin
            m_eotp = 1;
        end
        if (take) begin
            m_rdy[ohb] = 0; m_cnt[ohb] = 0; m_hb = 1 - ohb;
        end
        if (kill_ok) begin
            m_rdy[vic] = 0; m_cnt[vic] = 0;
            if (!ordy && m_cnt[owb] > 0) m_hb = owb;
            else                         m_wb = vic;
        end
        if ((give && !m_rdy[m_wb]) || (take && ohb == owb) || kill_ok) m_txr = 1;
        else if (tx_ack) m_txr = 0;
    endtask

    task automatic compare();
        int allow_e;
        allow_e = !m_rdy[m_wb] && m_cnt[m_wb] < N && !m_eotp;
        check("R2 wr_allow", int'(wr_allow), allow_e);
        check("R2 wr_count", int'(wr_count), m_cnt[m_wb]);
        check("R7 tx_ready", int'(tx_ready), m_txr);
        check("R7 tx_irq", int'(tx_irq), m_txr & int'(tx_ie));
        check("R9 hs_ready", int'(hs_ready), m_rdy[m_hb]);
        if (m_rdy[m_hb]) begin
            check("R9 hs_count", int'(hs_count), m_cnt[m_hb]);
            if (int'(hs_addr) < m_cnt[m_hb])
                check("R8 hs_data", int'(hs_data), m_mem[m_hb][hs_addr]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model();
        #1;
        compare();
    endtask

    task automatic do_reset(input logic a, input logic f);
        rst_n = 0; cfg_auto = a; cfg_flow = f;
        cpu_wr = 0; flow_wr = 0; flow_eot = 0; rel_bank = 0;
        tx_ack = 0; kill_bank = 0; hs_done = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic wr_cpu(input int v);
        cpu_wr = 1; cpu_data = DW'(v); step(); cpu_wr = 0;
    endtask
    task automatic wr_flow(input int v);
        flow_wr = 1; flow_data = DW'(v); step(); flow_wr = 0;
    endtask
    task automatic p_rel();  rel_bank = 1;  step(); rel_bank = 0;  endtask
    task automatic p_ack();  tx_ack = 1;    step(); tx_ack = 0;    endtask
    task automatic p_kill(); kill_bank = 1; step(); kill_bank = 0; endtask
    task automatic p_done(); hs_done = 1;   step(); hs_done = 0;   endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // manual mode, CPU port
        do_reset(0, 0);
        check("R1 reset wr_allow", int'(wr_allow), 1);
        check("R1 reset wr_count", int'(wr_count), 0);
        check("R1 reset tx_ready", int'(tx_ready), 1);
        check("R1 reset hs_ready", int'(hs_ready), 0);
        p_ack();
        check("R7 ack clears", int'(tx_ready), 0);
        wr_flow(5);
        check("R3 flow port ignored in CPU mode", int'(wr_count), 0);
        wr_cpu(10); wr_cpu(11); wr_cpu(12);
        check("R2 count after 3 writes", int'(wr_count), 3);
        p_rel();
        check("R4 partial handover ready", int'(hs_ready), 1);
        check("R4 partial handover count", int'(hs_count), 3);
        check("R7 set on handover with free bank", int'(tx_ready), 1);
        hs_addr = 1; step();
        check("R8 host byte 1", int'(hs_data), 11);
        for (int i = 0; i < N; i++) wr_cpu(20 + i);
        check("R2 full bank blocks", int'(wr_allow), 0);
        wr_cpu(99);
        check("R2 write while blocked ignored", int'(wr_count), N);
        p_ack();
        p_rel();
        check("R11 both pending blocks writer", int'(wr_allow), 0);
        check("R11 host keeps older bank", int'(hs_count), 3);
        check("R7 no set when other bank pending", int'(tx_ready), 0);
        p_kill();
        check("R10 kill frees newest bank", int'(wr_allow), 1);
        check("R10 kill keeps host bank", int'(hs_count), 3);
        check("R7 set on kill", int'(tx_ready), 1);
        p_done();
        check("R9 done frees host bank", int'(hs_ready), 0);
        p_kill();
        check("R10 kill with none pending", int'(hs_ready), 0);
        check("R10 kill with none pending count", int'(wr_count), 0);
        wr_cpu(30); wr_cpu(31); wr_cpu(32);
        p_rel();
        hs_addr = 0; step();
        check("R8 order after kill", int'(hs_data), 30);
        p_done();
        p_rel();
        check("R4 zero-length handover ready", int'(hs_ready), 1);
        check("R4 zero-length handover count", int'(hs_count), 0);
        p_done();

        // auto mode, CPU port
        do_reset(1, 0);
        for (int i = 0; i < N - 1; i++) wr_cpu(50 + i);
        check("R5 no handover before full", int'(hs_ready), 0);
        wr_cpu(50 + N - 1);
        check("R5 handover on fill", int'(hs_ready), 1);
        check("R5 handover count", int'(hs_count), N);
        check("R5 writer on fresh bank", int'(wr_count), 0);
        wr_cpu(70); wr_cpu(71);
        p_rel();
        check("R5 release ignored", int'(wr_count), 2);
        check("R5 release ignored host", int'(hs_count), N);

        // auto mode, flow port
        do_reset(1, 1);
        wr_cpu(77);
        check("R3 CPU port ignored in flow mode", int'(wr_count), 0);
        wr_flow(60); wr_flow(61); wr_flow(62);
        check("R3 flow writes counted", int'(wr_count), 3);
        flow_eot = 1; step(); flow_eot = 0;
        check("R6 eot blocks writer", int'(wr_allow), 0);
        check("R6 eot holds bank", int'(hs_ready), 0);
        wr_flow(63);
        check("R6 write after eot ignored", int'(wr_count), 3);
        p_rel();
        check("R6 release hands over", int'(hs_ready), 1);
        check("R6 release count", int'(hs_count), 3);
        check("R6 writer free again", int'(wr_allow), 1);
        hs_addr = 2; step();
        check("R8 flow byte order", int'(hs_data), 62);

        // randomized stream, every mode
        for (int m = 0; m < 4; m++) begin
            do_reset(m[0], m[1]);
            for (int c = 0; c < 1500; c++) begin
                cpu_wr    = ($urandom % 2) == 0;
                flow_wr   = ($urandom % 2) == 0;
                cpu_data  = DW'($urandom);
                flow_data = DW'($urandom);
                rel_bank  = ($urandom % 8) == 0;
                tx_ack    = ($urandom % 4) == 0;
                kill_bank = ($urandom % 16) == 0;
                hs_done   = ($urandom % 6) == 0;
                flow_eot  = ($urandom % 10) == 0;
                tx_ie     = ($urandom % 2) == 0;
                hs_addr   = IW'($urandom % N);
                step();
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule